// File: doc/BRIEF.md
# Dual-Code Serial Word Transmitter

This block takes 12-bit words from a 32-entry first-in first-out buffer. It sends each word serially, least significant bit first, and drives two logic-level line codes from the same bit stream at once. One output pair carries Harvard bi-phase. The other pair carries bipolar return-to-zero. Words follow each other with no gap for as long as the buffer has data. When the buffer runs dry, both encoders fall silent.

Bit timing is counted in pulses of a reference clock enable. A 3-bit rate code selects one of eight word rates, from 64 to 8192 words per second, and the rate doubles with each code step. A separate minimum-rate input forces the slowest rate, 32 words per second, whatever the code says. A bit lasts two half-bits. One half-bit lasts `BASE_HALF << (7 - code)` reference pulses, or `BASE_HALF << 8` pulses when the minimum-rate input is set. `BASE_HALF` is the half-bit length at the fastest rate.

The rate is captured at the start of every word. A change made during a word therefore applies from the next word onward.

The sequencer has three states:
- `TX_IDLE`: nothing is being sent.
- `TX_FIRST`: first half of a bit.
- `TX_SECOND`: second half of a bit.

It has five named transitions:
- *start*: `TX_IDLE` to `TX_FIRST` when the buffer holds a word. The word is popped at this point.
- *mid*: `TX_FIRST` to `TX_SECOND` when a half-bit ends.
- *next-bit*: `TX_SECOND` to `TX_FIRST` when a half-bit ends and more bits of the word remain.
- *chain*: `TX_SECOND` to `TX_FIRST` after the last bit of a word, when another word is waiting. That word is popped.
- *stop*: `TX_SECOND` to `TX_IDLE` after the last bit of a word, when the buffer is empty.

Top module: `dual_code_tx`

## Requirements
- R1: While reset is held, all four line outputs are low, `tx_empty` is 1 and `tx_full` is 0.
- R2: The buffer keeps up to 32 words in push order, and `tx_full` is 1 while it holds 32 words. A push while full is dropped, and that word is never sent.
- R3: A word pushed at clock edge n into an idle, empty block starts on the line right after edge n+1.
- R4: Each word is sent as 12 bits, bit 0 first. The next buffered word follows with no idle time between them.
- R5: With the minimum-rate input at 0, rate code c (0 to 7) gives a half-bit of `BASE_HALF << (7-c)` reference pulses. This is 64·2^c words per second.
- R6: With the minimum-rate input at 1, the half-bit is `BASE_HALF << 8` pulses for every rate code.
- R7: Only clock cycles with `ref_tick` = 1 advance bit timing. While `ref_tick` stays 0 during a word, the outputs hold.
- R8: The rate code and the minimum-rate input are sampled when a word is taken. Changes during a word apply from the next word.
- R9: Bi-phase: an internal level toggles at every bit start, and toggles again at mid-bit only for a 1. While sending, `hbp_a` shows the level and `hbp_b` shows its complement.
- R10: Return-to-zero: a 1 drives `bprz_a` high, and a 0 drives `bprz_b` high, for the first half-bit only. Both are low in the second half-bit.
- R11: When no word is being sent, all four line outputs are low.
- R12: `tx_empty` is 1 exactly when the buffer holds no word. It rises in the cycle after the last waiting word is taken for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Reference clock enable; one pulse is one timing unit |
| rate_code | input | 3 | Word-rate select; 0 is 64 words/s, 7 is 8192 words/s |
| min_rate | input | 1 | Forces 32 words/s when 1 |
| push | input | 1 | Write one word into the buffer |
| push_data | input | 12 | Word to write |
| tx_full | output | 1 | Buffer holds 32 words |
| tx_empty | output | 1 | Buffer holds no word |
| hbp_a | output | 1 | Bi-phase level |
| hbp_b | output | 1 | Bi-phase complement |
| bprz_a | output | 1 | Return-to-zero pulse for a 1 |
| bprz_b | output | 1 | Return-to-zero pulse for a 0 |

## Verification
The assertions assume reset is low from time zero. They also assume `ref_tick` pulses appear at an arbitrary rate, and that the rate inputs and `push` may change on any cycle. They make no assumption about the data value. The bench drives every input on the falling clock edge. It derives `ref_tick` from a fixed function of the cycle number. Its waveform model therefore knows, at each sample, whether the coming edge carries a timing pulse. This keeps the expected half-bit boundaries exact even in the sparse-pulse run.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_FIRST  = 2'd1,
        TX_SECOND = 2'd2
    } tx_state_e;

endpackage

// File: rtl/dct_fifo.sv
module dct_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           pop_data,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    assign empty    = (count == '0);
    assign full     = (count == (AW+1)'(DEPTH));
    assign fill     = count;
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/dct_halfbit_timer.sv
module dct_halfbit_timer #(
    parameter int BASE_HALF  = 1,
    parameter int RATE_STEPS = 8,
    parameter int CODE_W     = $clog2(RATE_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] rate_q,
    input  logic              slow_q,
    output logic              half_done
);
    localparam int MAX_LEN = BASE_HALF << RATE_STEPS;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] half_len;
    logic [LEN_W-1:0] cnt;

    // Half-bit length in reference pulses, from the rate held for this word.
    always_comb begin
        if (slow_q) begin
            half_len = LEN_W'(BASE_HALF) << RATE_STEPS;
        end else begin
            half_len = LEN_W'(BASE_HALF) << (CODE_W'(RATE_STEPS - 1) - rate_q);
        end
    end

    assign half_done = run && ref_tick && (cnt == half_len - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && ref_tick) begin
            cnt <= half_done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dct_sequencer.sv
module dct_sequencer #(
    parameter int WORD_W     = 12,
    parameter int RATE_STEPS = 8,
    parameter int CODE_W     = $clog2(RATE_STEPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 buf_empty,
    input  logic [WORD_W-1:0]    buf_data,
    input  logic                 half_done,
    input  logic [CODE_W-1:0]    rate_code,
    input  logic                 min_rate,
    output logic                 pop,
    output logic                 load,
    output logic                 bit_start,
    output logic                 mid_edge,
    output logic                 busy,
    output logic                 first_half,
    output logic                 cur_bit,
    output logic [CODE_W-1:0]    rate_q,
    output logic                 slow_q,
    output dct_pkg::tx_state_e   state
);
    import dct_pkg::*;

    localparam int CNT_W = $clog2(WORD_W);

    tx_state_e          state_nxt;
    logic [WORD_W-1:0]  shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_bit;
    logic               shift;

    assign last_bit = (bit_cnt == CNT_W'(WORD_W - 1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and the events that go with each transition.
    always_comb begin
        state_nxt = state;
        pop       = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        bit_start = 1'b0;
        mid_edge  = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (!buf_empty) begin          // start
                    pop       = 1'b1;
                    load      = 1'b1;
                    bit_start = 1'b1;
                    state_nxt = TX_FIRST;
                end
            end
            TX_FIRST: begin
                if (half_done) begin           // mid
                    mid_edge  = 1'b1;
                    state_nxt = TX_SECOND;
                end
            end
            TX_SECOND: begin
                if (half_done) begin
                    if (!last_bit) begin       // next-bit
                        shift     = 1'b1;
                        bit_start = 1'b1;
                        state_nxt = TX_FIRST;
                    end else if (!buf_empty) begin  // chain
                        pop       = 1'b1;
                        load      = 1'b1;
                        bit_start = 1'b1;
                        state_nxt = TX_FIRST;
                    end else begin             // stop
                        state_nxt = TX_IDLE;
                    end
                end
            end
            default: begin
                state_nxt = TX_IDLE;
            end
        endcase
    end

    // Outputs from the registered state.
    always_comb begin
        busy       = (state != TX_IDLE);
        first_half = (state == TX_FIRST);
        cur_bit    = shreg[0];
    end

    // Datapath: word shift register, bit counter and per-word rate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rate_q  <= '0;
            slow_q  <= 1'b0;
        end else if (load) begin
            shreg   <= buf_data;
            bit_cnt <= '0;
            rate_q  <= rate_code;
            slow_q  <= min_rate;
        end else if (shift) begin
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dct_biphase_enc.sv
module dct_biphase_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic bit_start,
    input  logic mid_edge,
    input  logic cur_bit,
    output logic line_a,
    output logic line_b
);
    logic level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else if (bit_start) begin
            level <= ~level;
        end else if (mid_edge && cur_bit) begin
            level <= ~level;
        end
    end

    assign line_a = busy & level;
    assign line_b = busy & ~level;

endmodule

// File: rtl/dct_rz_enc.sv
module dct_rz_enc (
    input  logic first_half,
    input  logic cur_bit,
    output logic line_a,
    output logic line_b
);
    assign line_a = first_half & cur_bit;
    assign line_b = first_half & ~cur_bit;

endmodule

// File: rtl/dual_code_tx.sv
module dual_code_tx #(
    parameter int WORD_W     = 12,
    parameter int DEPTH      = 32,
    parameter int RATE_STEPS = 8,
    parameter int BASE_HALF  = 1,
    parameter int CODE_W     = $clog2(RATE_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              min_rate,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              hbp_a,
    output logic              hbp_b,
    output logic              bprz_a,
    output logic              bprz_b
);
    localparam int FILL_W = $clog2(DEPTH) + 1;

    logic [WORD_W-1:0]   buf_data;
    logic [FILL_W-1:0]   fifo_fill;
    logic                pop;
    logic                load;
    logic                bit_start;
    logic                mid_edge;
    logic                busy;
    logic                first_half;
    logic                cur_bit;
    logic                half_done;
    logic [CODE_W-1:0]   rate_q;
    logic                slow_q;
    dct_pkg::tx_state_e  tx_state;

    dct_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (buf_data),
        .empty     (tx_empty),
        .full      (tx_full),
        .fill      (fifo_fill)
    );

    dct_sequencer #(.WORD_W(WORD_W), .RATE_STEPS(RATE_STEPS), .CODE_W(CODE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_empty  (tx_empty),
        .buf_data   (buf_data),
        .half_done  (half_done),
        .rate_code  (rate_code),
        .min_rate   (min_rate),
        .pop        (pop),
        .load       (load),
        .bit_start  (bit_start),
        .mid_edge   (mid_edge),
        .busy       (busy),
        .first_half (first_half),
        .cur_bit    (cur_bit),
        .rate_q     (rate_q),
        .slow_q     (slow_q),
        .state      (tx_state)
    );

    dct_halfbit_timer #(.BASE_HALF(BASE_HALF), .RATE_STEPS(RATE_STEPS), .CODE_W(CODE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .run       (busy),
        .restart   (load),
        .rate_q    (rate_q),
        .slow_q    (slow_q),
        .half_done (half_done)
    );

    dct_biphase_enc u_hbp (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .bit_start (bit_start),
        .mid_edge  (mid_edge),
        .cur_bit   (cur_bit),
        .line_a    (hbp_a),
        .line_b    (hbp_b)
    );

    dct_rz_enc u_rz (
        .first_half (first_half),
        .cur_bit    (cur_bit),
        .line_a     (bprz_a),
        .line_b     (bprz_b)
    );

endmodule

// File: rtl/dual_code_tx_checker.sv
module dual_code_tx_checker #(
    parameter int DEPTH  = 32,
    parameter int FILL_W = $clog2(DEPTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_tick,
    input logic               push,
    input logic               pop,
    input logic               tx_empty,
    input logic               busy,
    input dct_pkg::tx_state_e state,
    input logic [FILL_W-1:0]  fill,
    input logic               hbp_a,
    input logic               hbp_b,
    input logic               bprz_a,
    input logic               bprz_b
);
    import dct_pkg::*;

    assert_bprz_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bprz_a && bprz_b));

    assert_bprz_zero_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SECOND) |-> (!bprz_a && !bprz_b));

    assert_hbp_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hbp_a != hbp_b));

    assert_hbp_mid_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SECOND && $past(state) == TX_FIRST) |-> ((hbp_a ^ $past(hbp_a)) == $past(bprz_a)));

    assert_hbp_edge_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_FIRST && $past(state) == TX_SECOND) |-> (hbp_a != $past(hbp_a)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(hbp_a || hbp_b || bprz_a || bprz_b));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(DEPTH) && push && !pop) |=> (fill == FILL_W'(DEPTH)));

    assert_start_needs_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(tx_empty));

    assert_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_tick) |=> $stable({hbp_a, hbp_b, bprz_a, bprz_b}));

endmodule

bind dual_code_tx dual_code_tx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .push     (push),
    .pop      (pop),
    .tx_empty (tx_empty),
    .busy     (busy),
    .state    (tx_state),
    .fill     (fifo_fill),
    .hbp_a    (hbp_a),
    .hbp_b    (hbp_b),
    .bprz_a   (bprz_a),
    .bprz_b   (bprz_b)
);

// File: tb/dual_code_tx_bench.sv
module dual_code_tx_bench;
    localparam int BASE_HALF = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic [2:0]  rate_code = 3'd7;
    logic        min_rate = 1'b0;
    logic        push = 1'b0;
    logic [11:0] push_data = '0;
    logic        tx_full, tx_empty, hbp_a, hbp_b, bprz_a, bprz_b;

    dual_code_tx #(.BASE_HALF(BASE_HALF)) u_dual_code_tx (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_code(rate_code),
        .min_rate(min_rate), .push(push), .push_data(push_data),
        .tx_full(tx_full), .tx_empty(tx_empty), .hbp_a(hbp_a), .hbp_b(hbp_b),
        .bprz_a(bprz_a), .bprz_b(bprz_b)
    );

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tick_mode = 0;
    function automatic bit tick_at(input int n);
        return (tick_mode == 0) || (n % 3 == 0);
    endfunction

    // The pulse for the coming edge is a fixed function of its cycle number.
    always @(negedge clk) ref_tick <= tick_at(cyc + 1);

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  lvl_m = 0;
    int  first_push_cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int half_len(input int code, input bit slow);
        return slow ? (BASE_HALF << 8) : (BASE_HALF << (7 - code));
    endfunction

    task automatic push_list(input logic [11:0] words[$]);
        foreach (words[i]) begin
            @(negedge clk);
            if (i == 0) first_push_cyc = cyc;
            push = 1'b1;
            push_data = words[i];
        end
        @(negedge clk);
        push = 1'b0;
    endtask

    // Checks one contiguous run of words on all four outputs, then the idle line.
    task automatic check_stream(input logic [11:0] words[$], input int h_first,
                                input int h_rest, input string req);
        int guard = 0;
        bit first = 1;
        @(negedge clk);
        while (!(bprz_a || bprz_b) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        check(cyc == first_push_cyc + 2, "R3", "start cycle", cyc - first_push_cyc, 2);
        foreach (words[w]) begin
            int h = (w == 0) ? h_first : h_rest;
            for (int i = 0; i < 12; i++) begin
                bit b = words[w][i];
                bit err = 0;
                logic [3:0] got_e = '0;
                logic [3:0] exp_e = '0;
                lvl_m = ~lvl_m;
                for (int half = 0; half < 2; half++) begin
                    int ticks = 0;
                    logic [3:0] expv;
                    if (half == 1 && b) lvl_m = ~lvl_m;
                    expv = (half == 0) ? {lvl_m, ~lvl_m, b, ~b} : {lvl_m, ~lvl_m, 2'b00};
                    do begin
                        logic [3:0] got;
                        if (!first) @(negedge clk);
                        first = 0;
                        got = {hbp_a, hbp_b, bprz_a, bprz_b};
                        if (got !== expv && !err) begin
                            err = 1;
                            got_e = got;
                            exp_e = expv;
                        end
                        if (tick_at(cyc + 1)) ticks++;
                    end while (ticks < h);
                end
                check(!err, req, $sformatf("word %0d bit %0d lines", w, i), got_e, exp_e);
            end
        end
        @(negedge clk);
        check({hbp_a, hbp_b, bprz_a, bprz_b} == 4'b0000, "R11", "idle lines",
              {hbp_a, hbp_b, bprz_a, bprz_b}, 0);
        check(tx_empty == 1'b1, "R12", "empty after run", tx_empty, 1);
    endtask

    initial begin
        logic [11:0] wq[$];
        logic [11:0] kept[$];

        // R1 reset state
        repeat (3) @(negedge clk);
        check({hbp_a, hbp_b, bprz_a, bprz_b} == 4'b0000, "R1", "lines in reset",
              {hbp_a, hbp_b, bprz_a, bprz_b}, 0);
        check(tx_empty == 1'b1, "R1", "empty in reset", tx_empty, 1);
        check(tx_full == 1'b0, "R1", "full in reset", tx_full, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Single word at the fastest rate, with empty-flag timing (R12)
        wq = '{12'hA5C};
        fork
            begin
                push_list(wq);
                check(tx_empty == 1'b0, "R12", "word waiting", tx_empty, 0);
            end
            check_stream(wq, 1, 1, "R4 R9 R10");
        join
        repeat (3) @(negedge clk);

        // Sweep every rate code with two back-to-back words (R5, R4)
        for (int c = 0; c < 8; c++) begin
            rate_code = 3'(c);
            wq = '{12'hFFF ^ 12'(c * 12'h111), 12'h801 >> c};
            fork
                push_list(wq);
                check_stream(wq, half_len(c, 0), half_len(c, 0), "R5 R4");
            join
            repeat (2) @(negedge clk);
        end

        // Minimum-rate override over two different codes (R6)
        min_rate = 1'b1;
        rate_code = 3'd7;
        wq = '{12'h3C6};
        fork
            push_list(wq);
            check_stream(wq, half_len(7, 1), half_len(7, 1), "R6");
        join
        rate_code = 3'd0;
        wq = '{12'h000};
        fork
            push_list(wq);
            check_stream(wq, half_len(0, 1), half_len(0, 1), "R6");
        join
        min_rate = 1'b0;
        repeat (2) @(negedge clk);

        // Sparse reference pulses: one in three cycles (R7)
        tick_mode = 1;
        rate_code = 3'd6;
        wq = '{12'h5A3, 12'hFFE};
        fork
            push_list(wq);
            check_stream(wq, half_len(6, 0), half_len(6, 0), "R7");
        join
        tick_mode = 0;
        repeat (3) @(negedge clk);

        // Fill past 32, drop the extra word, change rate mid-word (R2, R8)
        min_rate = 1'b1;
        rate_code = 3'd0;
        wq = {};
        kept = {};
        for (int i = 0; i < 34; i++) begin
            wq.push_back(12'(i * 37 + 5));
            if (i < 33) kept.push_back(12'(i * 37 + 5));
        end
        fork
            begin
                push_list(wq);
                check(tx_full == 1'b1, "R2", "full after 34 pushes", tx_full, 1);
                min_rate = 1'b0;
                rate_code = 3'd7;
            end
            check_stream(kept, half_len(0, 1), half_len(7, 0), "R8 R2");
        join
        check(tx_full == 1'b0, "R2", "full cleared", tx_full, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule